// File: doc/BRIEF.md
# Bus Break Request Generator

This block lets a node that is not currently sending interrupt a long message that another node has on a shared serial bus. The local host raises a break request while the bus is busy. The block then counts complete bytes as the receiver reports them. After a fixed number of bytes it drives dominant zero bits onto the bus for one full byte time. The sending node sees its reflected data corrupted and is expected to stop. The breaking node then competes for the bus like any other node.

Only one break is allowed per request. If the breaking node loses the arbitration that follows, the block holds a "used" flag and refuses to force the bus again. The flag clears when the node wins arbitration or when the host drops its request. If the bus goes idle before the byte count is reached, or the host withdraws the request, the pending break is discarded and the bus is never driven.

All inputs and outputs are active high. `byteDone`, `bitTick` and `arbWon` are single-cycle strobes. `busIdle` and `breakReq` are levels.

Top module: `brk_generator`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `forceZero` and `breakUsed` are both 0.
- R2: Counting starts only when `breakReq`=1 and `busIdle`=0 while the block is neither counting, forcing nor used. Byte strobes seen while `busIdle`=1 are not counted.
- R3: `forceZero` rises in the cycle after the BREAK_BYTES-th `byteDone` strobe counted since arming (default 3), and never earlier.
- R4: `forceZero` stays 1 for exactly BYTE_BITS `bitTick` strobes (default 10). Cycles without a tick do not count. On the last tick, `forceZero` drops and `breakUsed` rises in the same cycle.
- R5: While `breakUsed`=1, `forceZero` stays 0 whatever bytes appear on the bus. This is the single-break limit after lost arbitration.
- R6: `breakUsed` clears in the cycle after `arbWon`=1 or `breakReq`=0. After that, a new break can be armed and forced.
- R7: `busIdle`=1 while counting cancels the break without driving the bus. A later arm starts the byte count from zero.
- R8: `breakReq`=0 while counting cancels the break without driving the bus.
- R9: Once forcing has started, `breakReq`, `busIdle` and `byteDone` have no effect until the forced byte time ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| breakReq | input | 1 | Host requests a break, level, active high |
| busIdle | input | 1 | Bus currently idle, level |
| byteDone | input | 1 | Receiver completed one byte, one-cycle strobe |
| bitTick | input | 1 | One bit time elapsed, one-cycle strobe |
| arbWon | input | 1 | This node won arbitration, one-cycle strobe |
| forceZero | output | 1 | Drive dominant zero onto the bus |
| breakUsed | output | 1 | Break already spent for this request |

## Verification
A wrong byte count shows at the ports as `forceZero` rising one or more byte strobes early or late. This is visible in the cycle after the strobe that should or should not have triggered it. A wrong bit counter shows as a forced byte that is one tick too short or too long, seen on the tick where `forceZero` should drop. A lost or stuck used state shows either as a second forced byte after more bus traffic, or as `breakUsed` failing to clear one cycle after a win or release. A counter that is not cleared on cancel shows as an early force after the next arm.

// File: rtl/brk_pkg.sv
package brk_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_FORCE = 2'd2,
    ST_SPENT = 2'd3
  } brkState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrByte;
    logic incByte;
    logic clrBit;
    logic incBit;
  } brkStrobe_t;

endpackage

// File: rtl/brk_datapath.sv
module brk_datapath
  import brk_pkg::*;
#(
  parameter int BREAK_BYTES = 3,
  parameter int BYTE_BITS   = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  brkStrobe_t strobe,
  output logic       byteLast,
  output logic       bitLast
);

  localparam int BYTE_W = (BREAK_BYTES > 1) ? $clog2(BREAK_BYTES) : 1;
  localparam int BIT_W  = (BYTE_BITS > 1) ? $clog2(BYTE_BITS) : 1;
  localparam logic [BYTE_W-1:0] BYTE_TOP = BYTE_W'(BREAK_BYTES - 1);
  localparam logic [BIT_W-1:0]  BIT_TOP  = BIT_W'(BYTE_BITS - 1);

  logic [BYTE_W-1:0] byteCnt;
  logic [BIT_W-1:0]  bitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteCnt <= '0;
    end else if (strobe.clrByte) begin
      byteCnt <= '0;
    end else if (strobe.incByte) begin
      byteCnt <= byteCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (strobe.clrBit) begin
      bitCnt <= '0;
    end else if (strobe.incBit) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  assign byteLast = (byteCnt == BYTE_TOP);
  assign bitLast  = (bitCnt == BIT_TOP);

endmodule

// File: rtl/brk_control.sv
module brk_control
  import brk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       breakReq,
  input  logic       busIdle,
  input  logic       byteDone,
  input  logic       bitTick,
  input  logic       arbWon,
  input  logic       byteLast,
  input  logic       bitLast,
  output brkStrobe_t strobe,
  output brkState_t  curState,
  output logic       forceZero,
  output logic       breakUsed
);

  brkState_t nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curState <= ST_IDLE;
    end else begin
      curState <= nextState;
    end
  end

  always_comb begin
    nextState = curState;
    strobe    = '0;
    unique case (curState)
      ST_IDLE: begin
        if (breakReq && !busIdle) begin
          nextState      = ST_COUNT;
          strobe.clrByte = 1'b1;
        end
      end
      ST_COUNT: begin
        if (!breakReq || busIdle) begin
          nextState = ST_IDLE;
        end else if (byteDone) begin
          if (byteLast) begin
            nextState     = ST_FORCE;
            strobe.clrBit = 1'b1;
          end else begin
            strobe.incByte = 1'b1;
          end
        end
      end
      ST_FORCE: begin
        if (bitTick) begin
          if (bitLast) begin
            nextState = ST_SPENT;
          end else begin
            strobe.incBit = 1'b1;
          end
        end
      end
      ST_SPENT: begin
        if (arbWon || !breakReq) begin
          nextState = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign forceZero = (curState == ST_FORCE);
  assign breakUsed = (curState == ST_SPENT);

endmodule

// File: rtl/brk_generator.sv
module brk_generator
  import brk_pkg::*;
#(
  parameter int BREAK_BYTES = 3,
  parameter int BYTE_BITS   = 10
) (
  input  logic clk,
  input  logic rstN,
  input  logic breakReq,
  input  logic busIdle,
  input  logic byteDone,
  input  logic bitTick,
  input  logic arbWon,
  output logic forceZero,
  output logic breakUsed
);

  brkStrobe_t strobe;
  brkState_t  curState;
  logic       byteLast;
  logic       bitLast;

  brk_control u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .breakReq (breakReq),
    .busIdle  (busIdle),
    .byteDone (byteDone),
    .bitTick  (bitTick),
    .arbWon   (arbWon),
    .byteLast (byteLast),
    .bitLast  (bitLast),
    .strobe   (strobe),
    .curState (curState),
    .forceZero(forceZero),
    .breakUsed(breakUsed)
  );

  brk_datapath #(
    .BREAK_BYTES(BREAK_BYTES),
    .BYTE_BITS  (BYTE_BITS)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .byteLast(byteLast),
    .bitLast (bitLast)
  );

endmodule

// File: rtl/brk_generator_checker.sv
module brk_generator_checker
  import brk_pkg::*;
(
  input logic      clk,
  input logic      rstN,
  input logic      breakReq,
  input logic      busIdle,
  input logic      byteDone,
  input logic      bitTick,
  input logic      arbWon,
  input logic      forceZero,
  input logic      breakUsed,
  input brkState_t curState
);

  AST_FORCE_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(forceZero) |-> $past(byteDone) && $past(breakReq) && !$past(busIdle)); // R3

  AST_FORCE_ENDS_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    $fell(forceZero) |-> $past(bitTick) && breakUsed); // R4

  AST_FORCE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    forceZero && !bitTick |=> forceZero); // R9

  AST_USED_FROM_FORCE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(breakUsed) |-> $past(forceZero)); // R5

  AST_USED_STICKS: assert property (@(posedge clk) disable iff (!rstN)
    breakUsed && breakReq && !arbWon |=> breakUsed && !forceZero); // R5

  AST_USED_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    breakUsed && (arbWon || !breakReq) |=> !breakUsed); // R6

  AST_IDLE_CANCELS: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_COUNT) && (busIdle || !breakReq) |=> curState == ST_IDLE && !forceZero); // R7

  AST_NO_ARM_ON_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_IDLE) && busIdle |=> curState == ST_IDLE); // R2

endmodule

bind brk_generator brk_generator_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .breakReq (breakReq),
  .busIdle  (busIdle),
  .byteDone (byteDone),
  .bitTick  (bitTick),
  .arbWon   (arbWon),
  .forceZero(forceZero),
  .breakUsed(breakUsed),
  .curState (curState)
);

// File: tb/brk_generator_test.sv
module brk_generator_test;

  typedef struct {
    logic  expForce;
    logic  expUsed;
    string tag;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic breakReq = 1'b0;
  logic busIdle = 1'b1;
  logic byteDone = 1'b0;
  logic bitTick = 1'b0;
  logic arbWon = 1'b0;
  logic forceZero;
  logic breakUsed;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  expItem_t scoreQ[$];

  always #5 clk = ~clk;

  brk_generator uut (
    .clk      (clk),
    .rstN     (rstN),
    .breakReq (breakReq),
    .busIdle  (busIdle),
    .byteDone (byteDone),
    .bitTick  (bitTick),
    .arbWon   (arbWon),
    .forceZero(forceZero),
    .breakUsed(breakUsed)
  );

  // driver: apply one cycle of inputs, queue the outputs expected after the next edge
  task automatic cyc(input logic req, input logic idle, input logic bd,
                     input logic tick, input logic won,
                     input logic eForce, input logic eUsed, input string tag);
    expItem_t it;
    @(negedge clk);
    breakReq = req;
    busIdle  = idle;
    byteDone = bd;
    bitTick  = tick;
    arbWon   = won;
    it.expForce = eForce;
    it.expUsed  = eUsed;
    it.tag      = tag;
    scoreQ.push_back(it);
  endtask

  // monitor: compare after each rising edge
  initial begin
    expItem_t it;
    forever begin
      @(posedge clk);
      #2;
      if (scoreQ.size() > 0) begin
        it = scoreQ.pop_front();
        checks++;
        if (forceZero !== it.expForce || breakUsed !== it.expUsed) begin
          errors++;
          $display("FAIL %s: forceZero/breakUsed = %b/%b, expected %b/%b",
                   it.tag, forceZero, breakUsed, it.expForce, it.expUsed);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    cyc(1, 0, 1, 1, 0, 0, 0, "R1 in reset");
    cyc(1, 0, 1, 1, 0, 0, 0, "R1 in reset");
    @(negedge clk);
    rstN = 1'b1;
    cyc(0, 1, 0, 0, 0, 0, 0, "R1 after reset");

    // R2: no arming while bus idle; bytes then are not counted
    cyc(1, 1, 1, 0, 0, 0, 0, "R2 idle bus no arm");
    cyc(1, 1, 1, 0, 0, 0, 0, "R2 idle bus no arm");
    cyc(1, 1, 1, 0, 0, 0, 0, "R2 idle bus no arm");
    cyc(1, 0, 0, 0, 0, 0, 0, "R2 arm on busy bus");
    // R3: three bytes, force after the third
    cyc(1, 0, 1, 0, 0, 0, 0, "R3 byte 1");
    cyc(1, 0, 0, 0, 0, 0, 0, "R3 gap");
    cyc(1, 0, 1, 0, 0, 0, 0, "R3 byte 2");
    cyc(1, 0, 1, 0, 0, 1, 0, "R3 byte 3 forces");
    // R4: ten ticks, gaps do not count
    for (int i = 0; i < 9; i++) begin
      cyc(1, 0, 0, 1, 0, 1, 0, "R4 forcing tick");
      cyc(1, 0, 0, 0, 0, 1, 0, "R4 no tick gap");
    end
    cyc(1, 0, 0, 1, 0, 0, 1, "R4 last tick releases");

    // R5: lost arbitration, more traffic, no second break
    for (int i = 0; i < 5; i++) begin
      cyc(1, 0, 1, 0, 0, 0, 1, "R5 no second break");
    end
    cyc(1, 1, 0, 0, 0, 0, 1, "R5 used across idle");

    // R6: win clears the limit, a new break can be armed
    cyc(1, 0, 0, 0, 1, 0, 0, "R6 win clears used");
    cyc(1, 0, 0, 0, 0, 0, 0, "R6 rearm");
    cyc(1, 0, 1, 0, 0, 0, 0, "R6 byte 1");
    cyc(1, 0, 1, 0, 0, 0, 0, "R6 byte 2");
    cyc(1, 0, 1, 0, 0, 1, 0, "R6 second break forces");
    // R9: request release, idle and bytes ignored while forcing
    cyc(0, 1, 1, 1, 0, 1, 0, "R9 ignore release/idle");
    for (int i = 0; i < 8; i++) begin
      cyc(0, 1, 1, 1, 0, 1, 0, "R9 still forcing");
    end
    cyc(0, 1, 0, 1, 0, 0, 1, "R9 byte time ends");
    cyc(0, 1, 0, 0, 0, 0, 0, "R6 release clears used");

    // R7: idle during count cancels, count restarts
    cyc(1, 0, 0, 0, 0, 0, 0, "R7 arm");
    cyc(1, 0, 1, 0, 0, 0, 0, "R7 byte 1");
    cyc(1, 0, 1, 0, 0, 0, 0, "R7 byte 2");
    cyc(1, 1, 1, 0, 0, 0, 0, "R7 idle cancels");
    cyc(1, 0, 1, 0, 0, 0, 0, "R7 rearm ignores byte");
    cyc(1, 0, 1, 0, 0, 0, 0, "R7 count from zero 1");
    cyc(1, 0, 1, 0, 0, 0, 0, "R7 count from zero 2");
    cyc(1, 0, 1, 0, 0, 1, 0, "R7 third byte forces");
    for (int i = 0; i < 9; i++) begin
      cyc(1, 0, 0, 1, 0, 1, 0, "R4 forcing tick");
    end
    cyc(0, 0, 0, 1, 0, 0, 1, "R4 release at end");
    cyc(0, 0, 0, 0, 0, 0, 0, "R6 release clears");

    // R8: request withdrawn while counting
    cyc(1, 0, 0, 0, 0, 0, 0, "R8 arm");
    cyc(1, 0, 1, 0, 0, 0, 0, "R8 byte 1");
    cyc(1, 0, 1, 0, 0, 0, 0, "R8 byte 2");
    cyc(0, 0, 1, 0, 0, 0, 0, "R8 release cancels");
    cyc(0, 0, 1, 0, 0, 0, 0, "R8 no force");
    cyc(0, 0, 1, 0, 0, 0, 0, "R8 no force");

    cyc(0, 1, 0, 0, 0, 0, 0, "R1 quiet");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule